// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event flags of a byte-oriented I2C master controller together with an interrupt-enable mask. It produces one combined interrupt line and two DMA request lines, one for each direction. The transfer logic raises flags through one-cycle set pulses. Software reads the flags through the status word. Software clears flags in one of two ways: by a write-one-to-clear store, or, in the older register model, by reading a vector register. Reading the vector returns the lowest pending enabled flag and acknowledges it.

The parameter `NEWER_REV` selects between two register models. The older model has a 5-bit enable mask, a read-only status word and a working vector register. The newer model has a 6-bit enable mask, write-one-to-clear status, and a self-test force of the low six flags. In the newer model the vector register reads as zero. All register inputs are plain strobes with no back-pressure: a write is taken in the cycle `wr_en` is high, and a vector read is taken in the cycle `vec_rd` is high. Register write selects are `wr_sel` = 0 for the enable mask, 1 for status clear, 2 for DMA configuration and 3 for self-test.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is asserted and right after it, the stored flags, `ie_mask` and `dma_cfg` are zero, `irq`, `rx_dma_req` and `tx_dma_req` are low, and `vec_value` is 0.
- R2: A pulse on `evt_set[b]` sets status bit b in the next cycle for b in {0,1,2,3,4,5,10,11,15}. Flag 1 = NACK, 2 = access-ready, 3 = receive-ready, 4 = transmit-ready, 10 = transmit underflow, 11 = receive overrun, 15 = single byte data. Bit 12 of `status_word` is the live `bus_busy` input. Every other bit reads 0.
- R3: `irq` is high exactly when `status_word[5:0] & ie_mask` is nonzero.
- R4: In the older model, `vec_value` is 1 + the index of the lowest set bit of `status_word[5:0] & ie_mask`, or 0 if no such bit is set. A cycle with `vec_rd` high clears that one flag in the next cycle.
- R5: In the newer model, `vec_value` is always 0, and `vec_rd` changes no flag.
- R6: A write with `wr_sel`=1 in the newer model clears each flag whose bit is 1 in `wr_data & 0x0027`. Flags 3 and 4 cannot be cleared this way. In the older model this write changes no flag.
- R7: A write with `wr_sel`=0 loads `ie_mask` from `wr_data[4:0]` in the older model (bit 5 stays 0), or from `wr_data[5:0]` in the newer model.
- R8: A write with `wr_sel`=2 loads `dma_cfg` with `wr_data & 0x8080`. Bit 15 enables receive DMA and bit 7 enables transmit DMA. When `wr_data[15]` is 1 the write also clears `ie_mask[3]`, and when `wr_data[7]` is 1 it clears `ie_mask[4]`.
- R9: `rx_dma_req` = `dma_cfg[15]` AND flag 3. `tx_dma_req` = `dma_cfg[7]` AND flag 4.
- R10: A write with `wr_sel`=3 and `wr_data[11]`=1 sets flags 0 to 5 in the newer model. In the older model it has no effect.
- R11: A flag that is set by `evt_set` in the same cycle as any clear (`evt_clr`, status write, or vector read) ends up set.
- R12: A pulse on `evt_clr[b]` clears flag b in the next cycle. This is the clear that the transfer logic uses for the ready flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | 16 | Flag set pulses, one bit per status position |
| evt_clr | input | 16 | Flag clear pulses from transfer logic |
| bus_busy | input | 1 | Live bus-busy indication, shown at status bit 12 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 status clear, 2 DMA config, 3 self-test |
| wr_data | input | 16 | Write data |
| vec_rd | input | 1 | Vector register read strobe |
| status_word | output | 16 | Status word |
| ie_mask | output | 6 | Interrupt enable mask |
| dma_cfg | output | 16 | DMA configuration (bits 15 and 7 only) |
| irq | output | 1 | Combined interrupt |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| vec_value | output | 3 | Vector read value |

## Verification
The assertions check four things on every cycle. The interrupt line must match the masked flags, and the receive request must match its enable and flag. A pulsed set must always survive into the next cycle, and a receive-DMA enable write must drop the receive-ready enable. The assertions also check that the vector never exceeds the mask width, that a vector read of flag 0 clears it, and that a status write in the older model leaves the flags untouched. The bench alone shows that the vector picks the lowest flag, and it does this by sweeping every flag pattern against every mask in both models. Only the bench's scenarios show the bit layout of the status word, which flags a status write may clear, the self-test force, and the dependence on the model choice.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int STAT_W = 16;
  localparam int ENA_W  = 6;
  localparam int VEC_W  = $clog2(ENA_W + 1);

  localparam int B_BUSY     = 12;
  localparam int B_RRDY     = 3;
  localparam int B_XRDY     = 4;
  localparam int B_RX_DMA   = 15;
  localparam int B_TX_DMA   = 7;
  localparam int B_FORCE    = 11;

  localparam logic [STAT_W-1:0] IMPL_MASK = 16'h8C3F;
  localparam logic [ENA_W-1:0]  W1C_MASK  = 6'h27;

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DMA  = 2'd2,
    SEL_TEST = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqv_status_regs.sv
module irqv_status_regs
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_pulse,
  input  logic [STAT_W-1:0] clr_pulse,
  input  logic [ENA_W-1:0]  sw_clr,
  input  logic [ENA_W-1:0]  vec_clr,
  input  logic              force_low,
  output logic [STAT_W-1:0] flags_q
);
  localparam int PAD_W = STAT_W - ENA_W;

  logic [STAT_W-1:0] clr_all;
  logic [STAT_W-1:0] set_all;
  logic [STAT_W-1:0] flags_d;

  always_comb begin
    clr_all = clr_pulse | {{PAD_W{1'b0}}, sw_clr} | {{PAD_W{1'b0}}, vec_clr};
    set_all = set_pulse | {{PAD_W{1'b0}}, {ENA_W{force_low}}};
    // sets are applied after clears so a same-cycle set wins
    flags_d = ((flags_q & ~clr_all) | set_all) & IMPL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/irqv_ctrl_regs.sv
module irqv_ctrl_regs
  import irqv_pkg::*;
#(
  parameter bit NEWER_REV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic [ENA_W-1:0]  mask_data,
  input  logic              wr_dma,
  input  logic              rx_en_bit,
  input  logic              tx_en_bit,
  output logic [ENA_W-1:0]  ie_mask_q,
  output logic              rx_dma_en_q,
  output logic              tx_dma_en_q
);
  localparam logic [ENA_W-1:0] KEEP = NEWER_REV ? 6'h3F : 6'h1F;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_mask_q   <= '0;
      rx_dma_en_q <= 1'b0;
      tx_dma_en_q <= 1'b0;
    end else if (wr_mask) begin
      ie_mask_q <= mask_data & KEEP;
    end else if (wr_dma) begin
      rx_dma_en_q <= rx_en_bit;
      tx_dma_en_q <= tx_en_bit;
      if (rx_en_bit) ie_mask_q[B_RRDY] <= 1'b0;
      if (tx_en_bit) ie_mask_q[B_XRDY] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqv_vector.sv
module irqv_vector
  import irqv_pkg::*;
#(
  parameter bit NEWER_REV = 1'b1
) (
  input  logic [ENA_W-1:0] pending,
  input  logic             rd_stb,
  output logic [VEC_W-1:0] vec_out,
  output logic [ENA_W-1:0] ack_clr
);
  generate
    if (NEWER_REV) begin : g_absent
      logic unused_vec;
      assign unused_vec = ^{pending, rd_stb};
      assign vec_out    = '0;
      assign ack_clr    = '0;
    end else begin : g_present
      logic [ENA_W-1:0] pick;
      logic [VEC_W-1:0] code;
      always_comb begin
        pick = '0;
        code = '0;
        for (int i = ENA_W - 1; i >= 0; i--) begin
          if (pending[i]) begin
            pick = '0;
            pick[i] = 1'b1;
            code = VEC_W'(i + 1);
          end
        end
      end
      assign vec_out = code;
      assign ack_clr = rd_stb ? pick : '0;
    end
  endgenerate
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqv_pkg::*;
#(
  parameter bit NEWER_REV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_set,
  input  logic [STAT_W-1:0] evt_clr,
  input  logic              bus_busy,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              vec_rd,
  output logic [STAT_W-1:0] status_word,
  output logic [ENA_W-1:0]  ie_mask,
  output logic [STAT_W-1:0] dma_cfg,
  output logic              irq,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic [VEC_W-1:0]  vec_value
);
  reg_sel_e          sel;
  logic              wr_mask, wr_stat, wr_dma, wr_test;
  logic [ENA_W-1:0]  sw_clr;
  logic [ENA_W-1:0]  vec_clr;
  logic              force_low;
  logic [STAT_W-1:0] flags_q;
  logic              rx_en, tx_en;
  logic [ENA_W-1:0]  pending;
  logic              unused_wr;

  assign sel       = reg_sel_e'(wr_sel);
  assign wr_mask   = wr_en && (sel == SEL_MASK);
  assign wr_stat   = wr_en && (sel == SEL_STAT);
  assign wr_dma    = wr_en && (sel == SEL_DMA);
  assign wr_test   = wr_en && (sel == SEL_TEST);
  assign sw_clr    = (NEWER_REV && wr_stat) ? (wr_data[ENA_W-1:0] & W1C_MASK) : '0;
  assign force_low = NEWER_REV && wr_test && wr_data[B_FORCE];
  assign unused_wr = ^{wr_data[14:12], wr_data[10:8], wr_data[6]};

  irqv_status_regs u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (evt_set),
    .clr_pulse (evt_clr),
    .sw_clr    (sw_clr),
    .vec_clr   (vec_clr),
    .force_low (force_low),
    .flags_q   (flags_q)
  );

  irqv_ctrl_regs #(.NEWER_REV(NEWER_REV)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_mask     (wr_mask),
    .mask_data   (wr_data[ENA_W-1:0]),
    .wr_dma      (wr_dma),
    .rx_en_bit   (wr_data[B_RX_DMA]),
    .tx_en_bit   (wr_data[B_TX_DMA]),
    .ie_mask_q   (ie_mask),
    .rx_dma_en_q (rx_en),
    .tx_dma_en_q (tx_en)
  );

  assign pending = flags_q[ENA_W-1:0] & ie_mask;

  irqv_vector #(.NEWER_REV(NEWER_REV)) u_vec (
    .pending (pending),
    .rd_stb  (vec_rd),
    .vec_out (vec_value),
    .ack_clr (vec_clr)
  );

  always_comb begin
    status_word         = flags_q;
    status_word[B_BUSY] = bus_busy;
    dma_cfg             = '0;
    dma_cfg[B_RX_DMA]   = rx_en;
    dma_cfg[B_TX_DMA]   = tx_en;
  end

  assign irq        = |pending;
  assign rx_dma_req = rx_en & flags_q[B_RRDY];
  assign tx_dma_req = tx_en & flags_q[B_XRDY];
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irqv_pkg::*;
#(
  parameter bit NEWER_REV = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [STAT_W-1:0] evt_set,
  input logic [STAT_W-1:0] evt_clr,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [STAT_W-1:0] wr_data,
  input logic              vec_rd,
  input logic [STAT_W-1:0] status_word,
  input logic [ENA_W-1:0]  ie_mask,
  input logic [STAT_W-1:0] dma_cfg,
  input logic              irq,
  input logic              rx_dma_req,
  input logic [VEC_W-1:0]  vec_value
);
  localparam logic [STAT_W-1:0] NO_BUSY = ~(STAT_W'(1) << B_BUSY);

  AST_IRQ_REFLECT: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(status_word[ENA_W-1:0] & ie_mask))); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_set & IMPL_MASK) != '0) |=>
      ((status_word & $past(evt_set & IMPL_MASK)) == $past(evt_set & IMPL_MASK))); // R11

  AST_RX_DMA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req == (dma_cfg[B_RX_DMA] && status_word[B_RRDY])); // R9

  AST_DMA_MASKS_RRDY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd2 && wr_data[B_RX_DMA]) |=> !ie_mask[B_RRDY]); // R8

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_value <= VEC_W'(ENA_W)); // R4

  AST_VEC_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && vec_value == VEC_W'(1) && !evt_set[0]) |=> !status_word[0]); // R4

  AST_OLD_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEWER_REV && wr_en && wr_sel == 2'd1 && evt_clr == '0 && evt_set == '0 && !vec_rd) |=>
      ((status_word & NO_BUSY) == ($past(status_word) & NO_BUSY))); // R6
endmodule

bind irq_status_unit irq_status_unit_chk #(.NEWER_REV(NEWER_REV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_set     (evt_set),
  .evt_clr     (evt_clr),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .vec_rd      (vec_rd),
  .status_word (status_word),
  .ie_mask     (ie_mask),
  .dma_cfg     (dma_cfg),
  .irq         (irq),
  .rx_dma_req  (rx_dma_req),
  .vec_value   (vec_value)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_set = '0, evt_clr = '0, wr_data = '0;
  logic        bus_busy = 1'b0, wr_en = 1'b0, vec_rd = 1'b0;
  logic [1:0]  wr_sel = '0;

  logic [15:0] sw_n, sw_o, dma_n, dma_o;
  logic [5:0]  msk_n, msk_o;
  logic        irq_n, irq_o, rx_n, rx_o, tx_n, tx_o;
  logic [2:0]  vec_n, vec_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_status_unit #(.NEWER_REV(1'b1)) i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
    .bus_busy(bus_busy), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec_rd(vec_rd), .status_word(sw_n), .ie_mask(msk_n), .dma_cfg(dma_n),
    .irq(irq_n), .rx_dma_req(rx_n), .tx_dma_req(tx_n), .vec_value(vec_n));

  irq_status_unit #(.NEWER_REV(1'b0)) i_irq_status_unit_old (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
    .bus_busy(bus_busy), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .vec_rd(vec_rd), .status_word(sw_o), .ie_mask(msk_o), .dma_cfg(dma_o),
    .irq(irq_o), .rx_dma_req(rx_o), .tx_dma_req(tx_o), .vec_value(vec_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus starting at a falling edge, return at the next
  task automatic cyc(input logic [15:0] s, input logic [15:0] c, input logic we,
                     input logic [1:0] sel, input logic [15:0] d, input logic vr);
    evt_set = s; evt_clr = c; wr_en = we; wr_sel = sel; wr_data = d; vec_rd = vr;
    @(negedge clk);
    evt_set = '0; evt_clr = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; vec_rd = 1'b0;
  endtask

  function automatic int lowest(input int v);
    for (int i = 0; i < 6; i++) if (v[i]) return i + 1;
    return 0;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    @(negedge clk);
    // R1 during reset
    chk("R1 status new", sw_n, 0); chk("R1 irq", irq_n | irq_o, 0);
    chk("R1 mask", msk_n | msk_o, 0); chk("R1 vec", vec_o, 0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 dma", dma_n | dma_o, 0);
    chk("R1 req", rx_n | tx_n | rx_o | tx_o, 0);

    // R2 bit positions, with busy live
    for (int b = 0; b < 16; b++) begin
      cyc(16'(1 << b), 16'hFFFF & ~16'(1 << b), 0, 0, 0, 0);
      chk("R2 set position", sw_n, (16'h8C3F & (1 << b)));
      cyc(0, 16'hFFFF, 0, 0, 0, 0);
      chk("R12 hw clear", sw_o, 0);
    end
    bus_busy = 1'b1; #1;
    chk("R2 busy live", sw_n, 16'h1000);
    bus_busy = 1'b0; #1;
    chk("R2 busy drop", sw_n, 0);

    // R7 mask width
    cyc(0, 0, 1, 0, 16'hFFFF, 0);
    chk("R7 mask new", msk_n, 6'h3F); chk("R7 mask old", msk_o, 6'h1F);

    // R8 DMA config masks ready enables
    cyc(0, 0, 1, 2, 16'hFFFF, 0);
    chk("R8 dma kept", dma_n, 16'h8080); chk("R8 mask new", msk_n, 6'h27);
    chk("R8 mask old", msk_o, 6'h07);

    // R9 requests follow flags
    cyc(16'h0008, 0, 0, 0, 0, 0);
    chk("R9 rx req", {rx_n, tx_n}, 2'b10);
    cyc(16'h0010, 16'h0008, 0, 0, 0, 0);
    chk("R9 tx req", {rx_n, tx_n, rx_o, tx_o}, 4'b0101);
    cyc(0, 0, 1, 2, 16'h0000, 0);
    chk("R9 disabled", {rx_n, tx_n}, 0);

    // R6 status write clears
    cyc(16'h8C3F, 0, 0, 0, 0, 0);
    cyc(0, 0, 1, 1, 16'hFFFF, 0);
    chk("R6 new w1c", sw_n, 16'h8C18); chk("R6 old ro", sw_o, 16'h8C3F);

    // R11 set beats clear
    cyc(16'h0002, 16'h0002, 1, 1, 16'h0002, 0);
    chk("R11 set wins new", sw_n[1], 1); chk("R11 set wins old", sw_o[1], 1);

    // R10 self-test force
    cyc(0, 16'hFFFF, 0, 0, 0, 0);
    cyc(0, 0, 1, 3, 16'h0800, 0);
    chk("R10 force new", sw_n, 16'h003F); chk("R10 force old", sw_o, 0);
    cyc(0, 16'hFFFF, 1, 3, 16'hF7FF, 0);
    chk("R10 no force", sw_n, 0);

    // R3 R4 R5 sweep over every flag pattern and mask
    for (int m = 0; m < 64; m++) begin
      for (int s = 0; s < 64; s++) begin
        cyc(0, 16'hFFFF, 1, 0, 16'(m), 0);
        cyc(16'(s), 0, 0, 0, 0, 0);
        chk("R3 irq new", irq_n, ((s & m) != 0));
        chk("R3 irq old", irq_o, ((s & m & 31) != 0));
        chk("R4 vec old", vec_o, lowest(s & m & 31));
        chk("R5 vec new", vec_n, 0);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R4 vec ack", sw_o,
            (lowest(s & m & 31) == 0) ? s : (s & ~(1 << (lowest(s & m & 31) - 1))));
        chk("R5 no ack", sw_n, s);
      end
    end

    // R11 vector ack against a set in the same cycle
    cyc(0, 16'hFFFF, 1, 0, 16'h001F, 0);
    cyc(16'h0004, 0, 0, 0, 0, 0);
    cyc(16'h0004, 0, 0, 0, 0, 1);
    chk("R11 vec vs set", sw_o, 16'h0004);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule